// File: doc/BRIEF.md
# Timestamp Coincidence Trigger Unit

This block forms a first-level trigger decision from two ordered streams of hit timestamps: a primary stream and a partner stream. Each stream enters its own small queue. A free-running real-time counter gives the current time, and a hit is only acted on once it lies further in the past than a programmable hold-off. The hold-off lets late hits from the other stream arrive before any decision is made, so the decision runs on a replay of the hits a fixed distance behind real time.

In coincidence mode, a primary hit triggers when a partner hit falls strictly after it and strictly less than the gate length after it. The gate window is therefore the stretch just before the partner hit. Veto mode triggers on primary hits that no partner matched, once the primary's window has expired. Union mode triggers on every hit of both streams, oldest first. A fourth mode drains both queues and never triggers. Every trigger is a one-cycle strobe that carries a timestamp. A programmable dead time suppresses triggers that follow too closely on the last one.

All time arithmetic is modulo 2^12, so counter wraparound is handled without special cases. The hold-off must be at least the gate length plus the largest delay between a hit's time and its arrival at the queue.

Top module: `coinc_trigger`

## Requirements
- R1: After reset `rt_now` is 0. It rises by one each clock and wraps from 4095 to 0.
- R2: A hit with timestamp t is not acted on while (rt_now − t) mod 4096 ≤ `hold_off`. A trigger appears one clock after its decision, so the earliest possible trigger has rt_now = t + hold_off + 2.
- R3: `trig_mode` = 0 (coincidence). A primary hit m triggers with `trig_time` = m when a partner hit s satisfies 0 < (s − m) < `gate_len` under signed modular difference. Equality at either bound does not match. A primary hit with no such partner is retired silently.
- R4: `trig_mode` = 2 (veto). A primary hit with no matching partner triggers with `trig_time` = m, in the cycle after its age first exceeds hold_off + gate_len. A matched primary hit produces no trigger.
- R5: `trig_mode` = 1 (union). Every hit of either stream triggers with its own timestamp, one per clock, oldest first. On equal timestamps the primary hit goes first.
- R6: `trig_mode` = 3 (drain). Hits are retired by the coincidence rules, but no trigger is issued. The queues are left empty.
- R7: After a trigger, decisions in the next `dead_len` clocks do not trigger. Their hits are still consumed.
- R8: Ordering and window tests use modular differences, so a pair straddling the wrap from 4095 to 0 matches like any other pair.
- R9: Each queue holds FIFO_DEPTH (8) hits. A push while the queue is full, with no pop in the same cycle, is discarded. `mst_full`/`slv_full` report a full queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_push | input | 1 | Primary hit strobe |
| mst_ts | input | 12 | Primary hit timestamp |
| slv_push | input | 1 | Partner hit strobe |
| slv_ts | input | 12 | Partner hit timestamp |
| hold_off | input | 12 | Replay distance behind real time, in clocks |
| gate_len | input | 12 | Window length ending at a partner hit |
| trig_mode | input | 2 | 0 coincidence, 1 union, 2 veto, 3 drain |
| dead_len | input | 8 | Clocks of trigger suppression after a trigger |
| mst_full | output | 1 | Primary queue full |
| slv_full | output | 1 | Partner queue full |
| rt_now | output | 12 | Real-time counter |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| trig_time | output | 12 | Timestamp of the last trigger |

## Verification
Two functions can fall in the same cycle: a hit becoming due for a trigger, and the dead-time counter still running from the previous trigger. This is provoked by primary hits with consecutive timestamps in union mode, so that one decision falls due every clock. The bench judges it by the exact count and timestamps of the triggers that survive. A behavioural queue model also compares strobe, timestamp and counter on every clock. The same model covers the case where a push meets a full queue while a pop is pending.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    parameter int TS_W = 12;
    parameter int DT_W = 8;

    typedef logic [TS_W-1:0] ts_t;

    typedef enum logic [1:0] {
        MODE_AND   = 2'd0,
        MODE_OR    = 2'd1,
        MODE_NOT   = 2'd2,
        MODE_DRAIN = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic pop_m;
        logic pop_s;
        logic fire;
        ts_t  ts;
    } decision_t;

    function automatic ts_t ts_age(ts_t now, ts_t t);
        return now - t;
    endfunction

endpackage

// File: rtl/time_base.sv
module time_base #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end
endmodule

// File: rtl/hit_fifo.sv
module hit_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         head_vld,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_push;

    assign full     = (count == (AW+1)'(DEPTH));
    assign head_vld = (count != '0);
    assign head     = mem[rd_ptr];
    assign do_push  = push && (!full || pop);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)     rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(pop);
        end
    end

    // R9: the controller never retires a hit from an empty queue
    p_pop_has_data_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_vld);

    // R9: a push into a full queue without a pop leaves the occupancy unchanged
    p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/coinc_ctrl.sv
module coinc_ctrl
    import coinc_pkg::*;
(
    input  ts_t        rt,
    input  ts_t        m_head,
    input  logic       m_vld,
    input  ts_t        s_head,
    input  logic       s_vld,
    input  ts_t        hold_off,
    input  ts_t        gate_len,
    input  trig_mode_e mode,
    output decision_t  dec
);
    ts_t                    m_age, s_age;
    logic [TS_W:0]          limit;
    logic signed [TS_W-1:0] d;
    logic                   m_ripe, s_ripe, m_expired, s_stale, m_hit;

    always_comb begin
        m_age     = ts_age(rt, m_head);
        s_age     = ts_age(rt, s_head);
        limit     = {1'b0, hold_off} + {1'b0, gate_len};
        d         = $signed(s_head - m_head);
        m_ripe    = m_vld && (m_age > hold_off);
        s_ripe    = s_vld && (s_age > hold_off);
        m_expired = m_vld && ({1'b0, m_age} > limit);
        s_stale   = s_ripe && (!m_vld || d <= 0);
        m_hit     = m_vld && s_vld && (d > 0) && (ts_t'(d) < gate_len);
    end

    always_comb begin
        dec = '0;
        if (mode == MODE_OR) begin
            if (m_ripe && (!s_ripe || d >= 0)) begin
                dec.pop_m = 1'b1;
                dec.fire  = 1'b1;
                dec.ts    = m_head;
            end else if (s_ripe) begin
                dec.pop_s = 1'b1;
                dec.fire  = 1'b1;
                dec.ts    = s_head;
            end
        end else begin
            dec.ts = m_head;
            if (s_stale) begin
                dec.pop_s = 1'b1;
            end else if (m_hit) begin
                if (m_ripe) begin
                    dec.pop_m = 1'b1;
                    dec.fire  = (mode == MODE_AND);
                end
            end else if (m_expired) begin
                dec.pop_m = 1'b1;
                dec.fire  = (mode == MODE_NOT);
            end
        end
    end
endmodule

// File: rtl/trig_gen.sv
module trig_gen
    import coinc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  ts_t             fire_ts,
    input  logic [DT_W-1:0] dead_len,
    output logic            trig_pulse,
    output ts_t             trig_time
);
    logic [DT_W-1:0] dead_cnt;
    logic            accept;

    assign accept = fire && (dead_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_pulse <= 1'b0;
            trig_time  <= '0;
            dead_cnt   <= '0;
        end else begin
            trig_pulse <= accept;
            if (accept) begin
                trig_time <= fire_ts;
                dead_cnt  <= dead_len;
            end else if (dead_cnt != '0) begin
                dead_cnt <= dead_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import coinc_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mst_push,
    input  logic [TS_W-1:0] mst_ts,
    input  logic            slv_push,
    input  logic [TS_W-1:0] slv_ts,
    input  logic [TS_W-1:0] hold_off,
    input  logic [TS_W-1:0] gate_len,
    input  logic [1:0]      trig_mode,
    input  logic [DT_W-1:0] dead_len,
    output logic            mst_full,
    output logic            slv_full,
    output logic [TS_W-1:0] rt_now,
    output logic            trig_pulse,
    output logic [TS_W-1:0] trig_time
);
    localparam int NSTREAM = 2;

    logic [NSTREAM-1:0] push_v, pop_v, vld_v, full_v;
    ts_t                din_v  [NSTREAM];
    ts_t                head_v [NSTREAM];
    decision_t          dec;

    assign push_v    = {slv_push, mst_push};
    assign din_v[0]  = mst_ts;
    assign din_v[1]  = slv_ts;
    assign pop_v     = {dec.pop_s, dec.pop_m};
    assign mst_full  = full_v[0];
    assign slv_full  = full_v[1];

    time_base #(.W(TS_W)) u_time (
        .clk (clk),
        .rst (rst),
        .now (rt_now)
    );

    for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
        hit_fifo #(.W(TS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push     (push_v[g]),
            .din      (din_v[g]),
            .pop      (pop_v[g]),
            .head     (head_v[g]),
            .head_vld (vld_v[g]),
            .full     (full_v[g])
        );
    end

    coinc_ctrl u_ctrl (
        .rt       (rt_now),
        .m_head   (head_v[0]),
        .m_vld    (vld_v[0]),
        .s_head   (head_v[1]),
        .s_vld    (vld_v[1]),
        .hold_off (hold_off),
        .gate_len (gate_len),
        .mode     (trig_mode_e'(trig_mode)),
        .dec      (dec)
    );

    trig_gen u_trig (
        .clk        (clk),
        .rst        (rst),
        .fire       (dec.fire),
        .fire_ts    (dec.ts),
        .dead_len   (dead_len),
        .trig_pulse (trig_pulse),
        .trig_time  (trig_time)
    );

    // checker state: clocks since the last trigger, saturating
    logic [DT_W-1:0] since_trig;
    always_ff @(posedge clk) begin
        if (rst)                   since_trig <= '1;
        else if (trig_pulse)       since_trig <= '0;
        else if (since_trig != '1) since_trig <= since_trig + 1'b1;
    end

    // R1: the real-time counter advances by exactly one per clock, modulo 2^TS_W
    p_rt_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rt_now == ts_t'($past(rt_now) + 1'b1)));

    // R2: a trigger's timestamp was older than the hold-off when it was decided
    p_ripe_r2: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> (ts_t'($past(rt_now) - trig_time) > $past(hold_off)));

    // R6: drain mode never lets a trigger out
    p_drain_silent_r6: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> ($past(trig_mode) != 2'd3));

    // R7: two triggers are separated by more than the dead time
    p_dead_gap_r7: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> (since_trig >= dead_len));
endmodule

// File: tb/coinc_trigger_test.sv
module coinc_trigger_test;
    localparam int W     = 12;
    localparam int MOD   = 4096;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mst_push = 1'b0, slv_push = 1'b0;
    logic [W-1:0] mst_ts = '0, slv_ts = '0;
    logic [W-1:0] hold_off = 12'd100, gate_len = 12'd8;
    logic [1:0]   trig_mode = 2'd0;
    logic [7:0]   dead_len = 8'd0;
    logic         mst_full, slv_full, trig_pulse;
    logic [W-1:0] rt_now, trig_time;

    int checks = 0, errors = 0;
    bit done = 0;

    coinc_trigger uut (
        .clk(clk), .rst(rst), .mst_push(mst_push), .mst_ts(mst_ts),
        .slv_push(slv_push), .slv_ts(slv_ts), .hold_off(hold_off),
        .gate_len(gate_len), .trig_mode(trig_mode), .dead_len(dead_len),
        .mst_full(mst_full), .slv_full(slv_full), .rt_now(rt_now),
        .trig_pulse(trig_pulse), .trig_time(trig_time)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int wrap(input int v);
        return ((v % MOD) + MOD) % MOD;
    endfunction

    function automatic int sdiff(input int m, input int s);
        int d;
        d = wrap(s - m);
        if (d >= MOD/2) d = d - MOD;
        return d;
    endfunction

    // ---------------- behavioural reference model ----------------
    int mq[$];
    int sq[$];
    int m_rt = 0, m_dead = 0, m_ts_exp = 0;
    bit m_trig = 0;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); sq.delete();
            m_rt = 0; m_dead = 0; m_ts_exp = 0; m_trig = 0;
        end else begin
            int mh, sh, ma, sa, d, fts;
            bit mv, sv, mr, sr, mexp, mhit, fire, pm, ps;
            mv = mq.size() > 0; sv = sq.size() > 0;
            mh = mv ? mq[0] : 0; sh = sv ? sq[0] : 0;
            ma = wrap(m_rt - mh); sa = wrap(m_rt - sh);
            d  = sdiff(mh, sh);
            mr = mv && ma > int'(hold_off);
            sr = sv && sa > int'(hold_off);
            mexp = mv && ma > int'(hold_off) + int'(gate_len);
            fire = 0; pm = 0; ps = 0; fts = 0;
            if (trig_mode == 2'd1) begin
                if (mr && (!sr || d >= 0)) begin pm = 1; fire = 1; fts = mh; end
                else if (sr) begin ps = 1; fire = 1; fts = sh; end
            end else begin
                mhit = mv && sv && d > 0 && d < int'(gate_len);
                if (sr && (!mv || d <= 0)) ps = 1;
                else if (mhit) begin
                    if (mr) begin pm = 1; fire = (trig_mode == 2'd0); fts = mh; end
                end else if (mexp) begin
                    pm = 1; fire = (trig_mode == 2'd2); fts = mh;
                end
            end
            if (pm) void'(mq.pop_front());
            if (ps) void'(sq.pop_front());
            m_trig = fire && m_dead == 0;
            if (m_trig) begin m_ts_exp = fts; m_dead = int'(dead_len); end
            else if (m_dead > 0) m_dead--;
            if (mst_push && mq.size() < DEPTH) mq.push_back(int'(mst_ts));
            if (slv_push && sq.size() < DEPTH) sq.push_back(int'(slv_ts));
            m_rt = wrap(m_rt + 1);
        end
    end

    // ---------------- observation: per-clock compare and trigger log ----------------
    int obs_cnt = 0, first_rt = -1, last_ts = -1;
    int ts_log[8];

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 rt_now vs model", int'(rt_now), m_rt);
            chk("R3/R4/R5/R7 trig_pulse vs model", int'(trig_pulse), int'(m_trig));
            chk("R3/R4/R5 trig_time vs model", int'(trig_time), m_ts_exp);
            if (trig_pulse) begin
                if (obs_cnt < 8) ts_log[obs_cnt] = int'(trig_time);
                if (obs_cnt == 0) first_rt = int'(rt_now);
                obs_cnt++;
                last_ts = int'(trig_time);
            end
        end
    end

    task automatic clear_obs();
        obs_cnt = 0; first_rt = -1; last_ts = -1;
    endtask

    task automatic push2(input bit mv, input int mt, input bit sv, input int st);
        @(negedge clk);
        mst_push = mv; mst_ts = W'(wrap(mt));
        slv_push = sv; slv_ts = W'(wrap(st));
        @(negedge clk);
        mst_push = 0; slv_push = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int base;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        chk("R1 rt_now one clock after reset", int'(rt_now), 1);
        chk("R7 trig_pulse idle after reset", int'(trig_pulse), 0);
        chk("R9 mst_full after reset", int'(mst_full), 0);
        idle(60);

        // R3 coincidence: d=1 matches, d=8 (=gate) and d=0 do not, d=7 matches
        trig_mode = 2'd0; clear_obs();
        base = wrap(int'(rt_now) - 45);
        push2(1, base,      1, base + 1);
        push2(1, base + 10, 1, base + 18);
        push2(1, base + 20, 1, base + 20);
        push2(1, base + 30, 1, base + 37);
        idle(300);
        chk("R3 coincidence trigger count", obs_cnt, 2);
        chk("R3 first trigger carries primary time", ts_log[0], base);
        chk("R3 second trigger carries primary time", last_ts, wrap(base + 30));
        chk("R2 earliest trigger time", first_rt, wrap(base + 102));

        // R4 veto mode
        trig_mode = 2'd2; clear_obs();
        base = wrap(int'(rt_now) - 45);
        push2(1, base,      1, base + 3);
        push2(1, base + 10, 1, base + 25);
        push2(1, base + 30, 0, 0);
        idle(300);
        chk("R4 veto trigger count", obs_cnt, 2);
        chk("R4 unmatched primary time", ts_log[0], wrap(base + 10));
        chk("R4 trigger after window deadline", first_rt, wrap(base + 120));
        chk("R4 last veto trigger", last_ts, wrap(base + 30));

        // R5 union mode, with a tie on equal timestamps
        trig_mode = 2'd1; clear_obs();
        base = wrap(int'(rt_now) - 45);
        push2(1, base, 1, base + 2);
        push2(1, base + 5, 1, base + 5);
        idle(300);
        chk("R5 union trigger count", obs_cnt, 4);
        chk("R5 order slot 0", ts_log[0], base);
        chk("R5 order slot 1", ts_log[1], wrap(base + 2));
        chk("R5 order slot 2", ts_log[2], wrap(base + 5));
        chk("R5 order slot 3", ts_log[3], wrap(base + 5));

        // R7 dead time overlapping consecutive due hits
        dead_len = 8'd6; clear_obs();
        base = wrap(int'(rt_now) - 45);
        for (int k = 0; k < 8; k++) push2(1, base + k, 0, 0);
        idle(300);
        chk("R7 surviving triggers", obs_cnt, 2);
        chk("R7 first survivor", ts_log[0], base);
        chk("R7 second survivor", last_ts, wrap(base + 7));
        dead_len = 8'd0;

        // R9 overflow of the primary queue
        clear_obs();
        base = wrap(int'(rt_now) - 45);
        for (int k = 0; k < 10; k++) push2(1, base + k, 0, 0);
        chk("R9 mst_full after ten pushes", int'(mst_full), 1);
        idle(300);
        chk("R9 triggers after overflow", obs_cnt, 8);
        chk("R9 last kept hit", last_ts, wrap(base + 7));
        chk("R9 mst_full after drain", int'(mst_full), 0);

        // R6 drain mode stays silent and empties the queues
        trig_mode = 2'd3; clear_obs();
        base = wrap(int'(rt_now) - 45);
        push2(1, base, 1, base + 1);
        push2(1, base + 10, 0, 0);
        idle(300);
        chk("R6 no trigger in drain mode", obs_cnt, 0);
        trig_mode = 2'd0;
        idle(300);
        chk("R6 queues left empty", obs_cnt, 0);

        // R1 / R8 wraparound
        while (rt_now != 12'd4095) @(negedge clk);
        @(negedge clk);
        chk("R1 counter wraps to zero", int'(rt_now), 0);
        while (rt_now != 12'd20) @(negedge clk);
        clear_obs();
        push2(1, 4094, 1, 1);
        push2(1, 5, 1, 13);
        idle(300);
        chk("R8 pair across wrap count", obs_cnt, 1);
        chk("R8 pair across wrap time", last_ts, 4094);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule